// File: doc/BRIEF.md
# Power-Failure Status and Restart Policy

This block sits in the power-management logic of a chipset. It watches the main power-good line, the active-low resume-well reset and the active-low real-time-clock-well reset, together with the current system sleep state. From these it keeps three sticky status flags and one restart-policy bit. Software reaches them through a small register port with two 8-bit registers. Each flag has its own set condition and its own clear rule.

When power-good falls, the block records the sleep state that was in effect at that moment. It then watches whether the resume-well reset also goes low before power-good returns. A dip in power-good alone is a glitch, and it always leads to a reboot. A dip that also takes down the resume-well reset is a full failure, and the policy bit picks the restart state. Once power-good has stayed high long enough, the block issues a one-cycle pulse that carries the chosen target state.

All inputs are synchronous to `clk`. `rst_n` is the block's own power-on reset. The two well resets act as synchronous inputs.

Top module: `pwr_fail_restart`

## Requirements
- R1: Register 0 (reg_addr=0) holds the power-good-failure flag at bit 0. Register 1 (reg_addr=1) holds the RTC-power flag at bit 2, the trickle-failure flag at bit 1 and the policy bit at bit 0. All other bits read 0 and ignore writes. Both registers read 00h after rst_n when rtc_rst_n is high. A read is combinational, and a write takes effect at the clock edge where reg_wr is high.
- R2: A fall of pwr_good sets the power-good-failure flag when sleep_st is S0 (3'd0) or S1 (3'd1). A fall is a sample low that follows a sample high taken since reset. A fall in S4 (3'd4) or S5 (3'd5) leaves the flag unchanged.
- R3: The power-good-failure flag clears when 1 is written to bit 0 of register 0. It also clears on every cycle in which sleep_st is G3 (3'd7). Writing 0 to that bit has no effect.
- R4: A fall of rsm_rst_n sets the trickle-failure flag. Writing 1 to bit 1 of register 1 clears it. A sample of rtc_rst_n low also clears it. Writing 0 to that bit, or a low level on rsm_rst_n, does not clear it.
- R5: The RTC-power flag is set on every cycle in which rtc_rst_n is sampled low. Writing 0 to bit 2 of register 1 clears it. Writing 1 to that bit has no effect.
- R6: The policy bit takes bit 0 of each write to register 1. A cycle with rtc_rst_n low or with sys_rst_wr high clears it, and this clear takes priority over the write. The resume-well reset does not affect the policy bit.
- R7: When a flag's set condition and a software clear of that flag fall in the same cycle, the flag ends up set.
- R8: If rsm_rst_n stays high for the whole time pwr_good is low, the restart target is S0, whatever the policy bit holds.
- R9: If rsm_rst_n is sampled low while pwr_good is low (a full failure) and the policy bit is 0, the restart target is S0.
- R10: After a full failure with the policy bit at 1, the target is S4 if sleep_st was S4 at the fall. Otherwise the target is S5. This holds even if sleep_st changes during the outage.
- R11: restart_vld is high for exactly one cycle. It rises after the clock edge that is the STABLE_CYC+1-th in a row to sample pwr_good high. Any low sample restarts the count. restart_tgt encodes 2'b00 for S0, 2'b01 for S5 and 2'b10 for S4, and it is 2'b00 whenever restart_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Main power-good level |
| rsm_rst_n | input | 1 | Active-low resume-well reset |
| rtc_rst_n | input | 1 | Active-low RTC-well reset |
| sleep_st | input | 3 | Current sleep state: S0=0, S1=1, S4=4, S5=5, G3=7 |
| sys_rst_wr | input | 1 | One-cycle strobe for a write to the system reset-control port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| restart_vld | output | 1 | One-cycle restart decision pulse |
| restart_tgt | output | 2 | Restart target state code |

## Verification
The hardest situation to reach is a restart decision that depends on history. One example is an S4 entry whose state was captured at the fall, after which sleep_st moves to G3 during the outage. Another is a power-good dip during the settling window that must restart the stability count. Directed outage sequences build these histories step by step: first the policy bit, then the state at the fall, then an optional resume-reset pulse in mid-outage, then an optional second dip. The bench measures the latency to the pulse and checks the target. A random phase with a fixed seed toggles all supply inputs, sleep states and writes every cycle. It compares each register read against a bench model, which catches any clash between set conditions and clears.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam logic [2:0] SLP_S0 = 3'd0;
  localparam logic [2:0] SLP_S1 = 3'd1;
  localparam logic [2:0] SLP_S4 = 3'd4;
  localparam logic [2:0] SLP_S5 = 3'd5;
  localparam logic [2:0] SLP_G3 = 3'd7;

  typedef enum logic [1:0] {
    TGT_S0 = 2'b00,
    TGT_S5 = 2'b01,
    TGT_S4 = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    ST_UP     = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2
  } rst_fsm_e;

  localparam logic ADDR_PG   = 1'b0;
  localparam logic ADDR_WELL = 1'b1;
  localparam int   BIT_PGF   = 0;
  localparam int   BIT_POL   = 0;
  localparam int   BIT_TRK   = 1;
  localparam int   BIT_RTS   = 2;
endpackage

// File: rtl/pfp_edge_sampler.sv
module pfp_edge_sampler #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] fall
);
  logic [W-1:0] q_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= d[i];
    end
    assign fall[i] = q_r[i] & ~d[i];
  end
endmodule

// File: rtl/pfp_status_regs.sv
module pfp_status_regs
  import pfp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_fall,
  input  logic              rsm_fall,
  input  logic              rtc_rst_n,
  input  logic [2:0]        sleep_st,
  input  logic              sys_rst_wr,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              policy,
  output logic [DATA_W-1:0] reg_rdata
);
  logic pgf_q, pgf_d, trk_q, trk_d, rts_q, rts_d, pol_q, pol_d;
  logic wr_pg, wr_well, pgf_set;

  always_comb begin
    wr_pg   = reg_wr && (reg_addr == ADDR_PG);
    wr_well = reg_wr && (reg_addr == ADDR_WELL);
    pgf_set = pg_fall && (sleep_st == SLP_S0 || sleep_st == SLP_S1);

    pgf_d = pgf_q;
    if (pgf_set) pgf_d = 1'b1;
    else if ((wr_pg && reg_wdata[BIT_PGF]) || sleep_st == SLP_G3) pgf_d = 1'b0;

    trk_d = trk_q;
    if (!rtc_rst_n) trk_d = 1'b0;
    else if (rsm_fall) trk_d = 1'b1;
    else if (wr_well && reg_wdata[BIT_TRK]) trk_d = 1'b0;

    rts_d = rts_q;
    if (!rtc_rst_n) rts_d = 1'b1;
    else if (wr_well && !reg_wdata[BIT_RTS]) rts_d = 1'b0;

    pol_d = pol_q;
    if (!rtc_rst_n || sys_rst_wr) pol_d = 1'b0;
    else if (wr_well) pol_d = reg_wdata[BIT_POL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgf_q <= 1'b0;
      trk_q <= 1'b0;
      rts_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      pgf_q <= pgf_d;
      trk_q <= trk_d;
      rts_q <= rts_d;
      pol_q <= pol_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_PG) begin
      reg_rdata[BIT_PGF] = pgf_q;
    end else begin
      reg_rdata[BIT_RTS] = rts_q;
      reg_rdata[BIT_TRK] = trk_q;
      reg_rdata[BIT_POL] = pol_q;
    end
  end

  assign policy = pol_q;

  p_pgf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pgf_set |=> pgf_q);
  p_pgf_g3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_st == SLP_G3) |=> !pgf_q);
  p_trk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && rtc_rst_n && !(wr_well && reg_wdata[BIT_TRK])) |=> trk_q);
  p_rts_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_rst_n |=> rts_q);
  p_pol_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_rst_n || sys_rst_wr) |=> !pol_q);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_fall && rtc_rst_n) |=> trk_q);
endmodule

// File: rtl/pfp_restart_fsm.sv
module pfp_restart_fsm
  import pfp_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       pg_fall,
  input  logic       rsm_rst_n,
  input  logic [2:0] sleep_st,
  input  logic       policy,
  output logic       restart_vld,
  output logic [1:0] restart_tgt
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);

  rst_fsm_e   state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0] lat_q, lat_d;
  logic       full_q, full_d, vld_q, vld_d;
  tgt_e       tgt_q, tgt_d, pick;

  always_comb begin
    if (!full_q || !policy)   pick = TGT_S0;
    else if (lat_q == SLP_S4) pick = TGT_S4;
    else                      pick = TGT_S5;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    full_d  = full_q;
    vld_d   = 1'b0;
    tgt_d   = TGT_S0;
    unique case (state_q)
      ST_UP: if (pg_fall) begin
        state_d = ST_DOWN;
        lat_d   = sleep_st;
        full_d  = !rsm_rst_n;
      end
      ST_DOWN: begin
        full_d = full_q | !rsm_rst_n;
        if (pwr_good) begin
          state_d = ST_SETTLE;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_SETTLE: begin
        if (!pwr_good) begin
          state_d = ST_DOWN;
          full_d  = full_q | !rsm_rst_n;
        end else if (cnt_q == CNT_W'(STABLE_CYC)) begin
          state_d = ST_UP;
          vld_d   = 1'b1;
          tgt_d   = pick;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_UP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UP;
      cnt_q   <= '0;
      lat_q   <= SLP_S0;
      full_q  <= 1'b0;
      vld_q   <= 1'b0;
      tgt_q   <= TGT_S0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      full_q  <= full_d;
      vld_q   <= vld_d;
      tgt_q   <= tgt_d;
    end
  end

  assign restart_vld = vld_q;
  assign restart_tgt = tgt_q;

  p_pulse_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_vld |=> !restart_vld);
  p_tgt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_vld |-> (restart_tgt == TGT_S0));
  p_no_pulse_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !restart_vld);
  p_glitch_s0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_UP && !full_q && rsm_rst_n) |=> (restart_tgt == TGT_S0));
  p_s4_needs_pol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_vld && restart_tgt == TGT_S4) |-> policy);
endmodule

// File: rtl/pwr_fail_restart.sv
module pwr_fail_restart
  import pfp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STABLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              rsm_rst_n,
  input  logic              rtc_rst_n,
  input  logic [2:0]        sleep_st,
  input  logic              sys_rst_wr,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              restart_vld,
  output logic [1:0]        restart_tgt
);
  localparam int N_SAMP = 2;

  logic [N_SAMP-1:0] falls;
  logic              policy;

  pfp_edge_sampler #(.W(N_SAMP)) u_samp (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({rsm_rst_n, pwr_good}),
    .fall (falls)
  );

  pfp_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pg_fall   (falls[0]),
    .rsm_fall  (falls[1]),
    .rtc_rst_n (rtc_rst_n),
    .sleep_st  (sleep_st),
    .sys_rst_wr(sys_rst_wr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .policy    (policy),
    .reg_rdata (reg_rdata)
  );

  pfp_restart_fsm #(.STABLE_CYC(STABLE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .pg_fall    (falls[0]),
    .rsm_rst_n  (rsm_rst_n),
    .sleep_st   (sleep_st),
    .policy     (policy),
    .restart_vld(restart_vld),
    .restart_tgt(restart_tgt)
  );
endmodule

// File: tb/sim_pwr_fail_restart.sv
`timescale 1ns/1ps
module sim_pwr_fail_restart;
  localparam int STABLE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 1'b1, rsm_rst_n = 1'b1, rtc_rst_n = 1'b1, sys_rst_wr = 1'b0;
  logic [2:0] sleep_st = 3'd0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic restart_vld;
  logic [1:0] restart_tgt;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the flags
  logic m_pgf, m_trk, m_rts, m_pol, m_pgq, m_rsmq;

  always #10 clk = ~clk;

  pwr_fail_restart #(.DATA_W(8), .STABLE_CYC(STABLE)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .rsm_rst_n(rsm_rst_n),
    .rtc_rst_n(rtc_rst_n), .sleep_st(sleep_st), .sys_rst_wr(sys_rst_wr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .restart_vld(restart_vld), .restart_tgt(restart_tgt)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input string req, input logic a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    m_pgf = 0; m_trk = 0; m_rts = 0; m_pol = 0; m_pgq = 0; m_rsmq = 0;
  endtask

  function automatic logic [7:0] model_read(input logic a);
    return a ? {5'b0, m_rts, m_trk, m_pol} : {7'b0, m_pgf};
  endfunction

  task automatic model_step();
    logic w0, w1;
    w0 = reg_wr && !reg_addr;
    w1 = reg_wr && reg_addr;
    if (m_pgq && !pwr_good && (sleep_st == 3'd0 || sleep_st == 3'd1)) m_pgf = 1;
    else if ((w0 && reg_wdata[0]) || sleep_st == 3'd7) m_pgf = 0;
    if (!rtc_rst_n) m_trk = 0;
    else if (m_rsmq && !rsm_rst_n) m_trk = 1;
    else if (w1 && reg_wdata[1]) m_trk = 0;
    if (!rtc_rst_n) m_rts = 1;
    else if (w1 && !reg_wdata[2]) m_rts = 0;
    if (!rtc_rst_n || sys_rst_wr) m_pol = 0;
    else if (w1) m_pol = reg_wdata[0];
    m_pgq = pwr_good;
    m_rsmq = rsm_rst_n;
  endtask

  task automatic outage(input string req, input logic pol, input logic [2:0] st,
                        input bit full, input bit dip, input logic [1:0] exp);
    int n;
    wr(1'b1, {5'b0, 1'b1, 1'b0, pol});
    sleep_st = st;
    tick();
    pwr_good = 1'b0;
    tick();
    sleep_st = 3'd7;
    if (full) rsm_rst_n = 1'b0;
    tick();
    rsm_rst_n = 1'b1;
    tick();
    if (dip) begin
      pwr_good = 1'b1; tick(); tick();
      pwr_good = 1'b0; tick();
    end
    sleep_st = 3'd0;
    pwr_good = 1'b1;
    n = 0;
    while (n < 20) begin
      @(posedge clk); n++;
      @(negedge clk); #1;
      if (restart_vld) break;
    end
    check({req, " latency"}, 8'(n), 8'(STABLE + 1));
    check({req, " target"}, {6'b0, restart_tgt}, {6'b0, exp});
    tick(); #1;
    check("R11 single pulse", {7'b0, restart_vld}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] st_pick [5] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd7};
    void'($urandom(32'd1234));
    // random phase against the bench model
    do_reset();
    for (int i = 0; i < 500; i++) begin
      logic a;
      a = reg_addr;
      #1;
      check(a ? "R4 random well register" : "R2 random pg register", reg_rdata, model_read(a));
      pwr_good   = ($urandom % 4) != 0;
      rsm_rst_n  = ($urandom % 5) != 0;
      rtc_rst_n  = ($urandom % 12) != 0;
      sys_rst_wr = ($urandom % 10) == 0;
      sleep_st   = st_pick[$urandom % 5];
      reg_wr     = ($urandom % 3) == 0;
      reg_addr   = 1'($urandom);
      reg_wdata  = 8'($urandom);
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
    reg_wr = 0; sys_rst_wr = 0; pwr_good = 1; rsm_rst_n = 1; rtc_rst_n = 1; sleep_st = 0;
    repeat (20) tick();

    // directed
    do_reset();
    rd("R1 reset pg reg", 1'b0, 8'h00);
    rd("R1 reset well reg", 1'b1, 8'h00);
    check("R11 reset pulse", {7'b0, restart_vld}, 8'h00);
    wr(1'b1, 8'hFF);
    rd("R1 reserved/policy write", 1'b1, 8'h01);
    wr(1'b0, 8'hFE);
    rd("R1 reserved pg bits", 1'b0, 8'h00);
    sys_rst_wr = 1'b1; tick(); sys_rst_wr = 1'b0;
    rd("R6 reset-port clears policy", 1'b1, 8'h00);
    wr(1'b1, 8'h01);
    rsm_rst_n = 1'b0; tick(); rsm_rst_n = 1'b1; tick();
    rd("R4 trickle set, R6 policy kept", 1'b1, 8'h03);
    wr(1'b1, 8'h05);
    rd("R4 write0 keeps trickle", 1'b1, 8'h03);
    wr(1'b1, 8'h03);
    rd("R4 write1 clears trickle", 1'b1, 8'h01);
    rtc_rst_n = 1'b0; tick(); rtc_rst_n = 1'b1;
    rd("R5 rtc flag set, R6 policy cleared", 1'b1, 8'h04);
    wr(1'b1, 8'h04);
    rd("R5 write1 keeps rtc flag", 1'b1, 8'h04);
    wr(1'b1, 8'h00);
    rd("R5 write0 clears rtc flag", 1'b1, 8'h00);

    sleep_st = 3'd0; pwr_good = 1'b0; tick(); pwr_good = 1'b1;
    rd("R2 fall in S0 sets", 1'b0, 8'h01);
    wr(1'b0, 8'h00);
    rd("R3 write0 keeps", 1'b0, 8'h01);
    wr(1'b0, 8'h01);
    rd("R3 write1 clears", 1'b0, 8'h00);
    repeat (10) tick();
    sleep_st = 3'd5; pwr_good = 1'b0; tick(); pwr_good = 1'b1;
    rd("R2 fall in S5 ignored", 1'b0, 8'h00);
    repeat (10) tick();
    sleep_st = 3'd1; pwr_good = 1'b0; tick();
    rd("R2 fall in S1 sets", 1'b0, 8'h01);
    sleep_st = 3'd7; tick();
    rd("R3 G3 clears", 1'b0, 8'h00);
    sleep_st = 3'd0; pwr_good = 1'b1;
    repeat (10) tick();
    pwr_good = 1'b0;
    wr(1'b0, 8'h01);
    rd("R7 pg set beats clear", 1'b0, 8'h01);
    rsm_rst_n = 1'b0;
    wr(1'b1, 8'h02);
    rsm_rst_n = 1'b1;
    rd("R7 trickle set beats clear", 1'b1, 8'h02);
    pwr_good = 1'b1;
    repeat (10) tick();

    outage("R8 glitch policy1", 1'b1, 3'd5, 0, 0, 2'b00);
    outage("R9 full policy0", 1'b0, 3'd4, 1, 0, 2'b00);
    outage("R10 full policy1 S5", 1'b1, 3'd5, 1, 0, 2'b01);
    outage("R10 full policy1 S4", 1'b1, 3'd4, 1, 0, 2'b10);
    outage("R10 full policy1 S0", 1'b1, 3'd0, 1, 0, 2'b01);
    outage("R11 dip restarts count", 1'b1, 3'd4, 1, 1, 2'b10);
    outage("R8 glitch with dip", 1'b1, 3'd4, 0, 1, 2'b00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule